// File: doc/BRIEF.md
# Mapped Vectored Interrupt Controller

This block gathers 64 active-low interrupt sources into one interrupt request for a CPU. Each source can be configured for level or edge detection. Its event is latched in a pending flag, and that flag can be gated by an enable flag. The block reports the lowest-numbered enabled pending source through a read-only vector register.

Software sees the enable and pending flags as two 32-bit words each, a high word and a low word. A source does not sit at the bit position its number suggests. A fixed table places each source in one word and gives it a bit number. Bit numbers count from the most significant end, so bit number b sits at register position 31−b.

The block is accessed through a simple synchronous register port. Writes take effect on the clock edge. Reads return combinationally from the current address.

Top module: `irq_map_ctrl`

## Requirements
- R1: After reset, both enable words, both pending words, the trigger word and the vector register read 0, and `irq_o` is low.
- R2: Writing 1 to an enable bit enables its source and writing 0 blocks it. `irq_o` is high exactly when some source has both its pending flag and its enable flag set.
- R3: Placement of sources in the words:
  - Sources 0–15 and 32–47 live in the high word; sources 16–31 and 48–63 live in the low word.
  - Bit numbers: source 0 is bit 31 and sources 1–15 are bits 16–30.
  - Source 16 is bit 29, source 17 is bit 30, sources 18–30 are bits 16–28 and source 31 is bit 31.
  - Sources 32–47 are bits 0–15 ascending, and sources 48–63 are bits 15 down to 0.
- R4: Bit number b occupies register position 31−b in the enable and pending words.
- R5: A level-mode source sets its pending flag while its input is low. A pending flag cleared while the input is still low becomes set again.
- R6: Trigger register bit s (s = 0..31, position s) set to 1 puts source s in falling-edge mode, where only a high-to-low transition sets pending. Sources 32–63 are always level mode.
- R7: Writing a pending word clears each flag whose bit is 1 in the written data. Bits written as 0 leave their flag unchanged.
- R8: The vector register holds, in bits 31:26, the lowest-numbered source that is both pending and enabled, or 0 if there is none. Its bits 25:0 read 0.
- R9: A detection and a software clear that hit the same flag on the same clock edge leave the flag set.
- R10: Register byte offsets:
  - 0x00: high enable word
  - 0x04: low enable word
  - 0x08: high pending word
  - 0x0C: low pending word
  - 0x10: vector
  - 0x14: trigger
  
  Writes to the vector register, to other offsets and to unaligned addresses change nothing, and such other or unaligned addresses read 0.
- R11: An input change is first visible in the pending flag on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ni | input | 64 | Raw interrupt sources, active low, indexed by source number |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (5) | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A detected falling edge and a write-one-to-clear of the same pending flag can land on the same clock edge. The bench provokes this collision directly on a source in edge mode. It drives the falling input and then raises the clear strobe on the cycle before the third rising edge. It expects the flag to survive, and a second clear with no edge must then empty it. Random traffic adds further collisions against level sources that stay low: the bench model re-sets those flags after every clear, and each register's contents are compared with the model after the inputs settle.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  localparam int NUM_SRC  = 64;
  localparam int DATA_W   = 32;
  localparam int VEC_W    = $clog2(NUM_SRC);
  localparam int EDGE_SRC = 32;

  // register word indices (byte offset / 4)
  localparam int IDX_MASK_HI = 0;
  localparam int IDX_MASK_LO = 1;
  localparam int IDX_PEND_HI = 2;
  localparam int IDX_PEND_LO = 3;
  localparam int IDX_VEC     = 4;
  localparam int IDX_EDGE    = 5;

  function automatic logic src_is_hi(int s);
    return ((s / 16) % 2) == 0;
  endfunction

  // MSB-first bit number of a source within its word
  function automatic int src_bitnum(int s);
    int b;
    case (s / 16)
      0:       b = (s == 0) ? 31 : s + 15;
      1:       b = (s == 16) ? 29 : (s == 17) ? 30 : (s == 31) ? 31 : s - 2;
      2:       b = s - 32;
      default: b = 63 - s;
    endcase
    return b;
  endfunction

  function automatic logic [4:0] src_pos(int s);
    return 5'(31 - src_bitnum(s));
  endfunction
endpackage

// File: rtl/irq_in_detect.sv
module irq_in_detect #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_ni,
  input  logic [N-1:0] edge_i,
  output logic [N-1:0] det_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= src_ni;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign det_o[i] = edge_i[i] ? (prev_q[i] & ~sync_q[i]) : ~sync_q[i];
  end

  // R6: an edge-mode source never detects on two consecutive cycles
  a_r6_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_i & det_o & $past(edge_i & det_o)) == '0));
endmodule

// File: rtl/irq_lowest_sel.sv
module irq_lowest_sel #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl
  import irq_map_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic aligned;
  logic wr_mask_hi, wr_mask_lo, wr_pend_hi, wr_pend_lo, wr_edge;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  assign wr_mask_hi = wr_en_i & aligned & (word == WORD_W'(IDX_MASK_HI));
  assign wr_mask_lo = wr_en_i & aligned & (word == WORD_W'(IDX_MASK_LO));
  assign wr_pend_hi = wr_en_i & aligned & (word == WORD_W'(IDX_PEND_HI));
  assign wr_pend_lo = wr_en_i & aligned & (word == WORD_W'(IDX_PEND_LO));
  assign wr_edge    = wr_en_i & aligned & (word == WORD_W'(IDX_EDGE));

  logic [NUM_SRC-1:0] mask_q, mask_d, pend_q, pend_d, clr_v, det_v, edge_v;
  logic [EDGE_SRC-1:0] edge_q;

  // per-source state, addressed through the fixed word/bit table
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam logic [4:0] P = src_pos(s);
    localparam logic       H = src_is_hi(s);
    logic wm, wp;
    assign wm        = H ? wr_mask_hi : wr_mask_lo;
    assign wp        = H ? wr_pend_hi : wr_pend_lo;
    assign mask_d[s] = wm ? wdata_i[P] : mask_q[s];
    assign clr_v[s]  = wp & wdata_i[P];
    if (s < EDGE_SRC) begin : g_cfg
      assign edge_v[s] = edge_q[s];
    end else begin : g_lvl
      assign edge_v[s] = 1'b0;
    end
  end

  irq_in_detect #(.N(NUM_SRC)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_ni (src_ni),
    .edge_i (edge_v),
    .det_o  (det_v)
  );

  // new detection wins over a same-edge clear
  assign pend_d = (pend_q & ~clr_v) | det_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      edge_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      if (wr_edge) edge_q <= wdata_i[EDGE_SRC-1:0];
    end
  end

  logic [VEC_W-1:0] sel_idx;
  logic             sel_any;

  irq_lowest_sel #(.N(NUM_SRC)) u_sel (
    .req_i (pend_q & mask_q),
    .idx_o (sel_idx),
    .any_o (sel_any)
  );

  assign irq_o = sel_any;

  logic [DATA_W-1:0] mask_hi, mask_lo, pend_hi, pend_lo;

  always_comb begin
    mask_hi = '0;
    mask_lo = '0;
    pend_hi = '0;
    pend_lo = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_is_hi(s)) begin
        mask_hi[src_pos(s)] = mask_q[s];
        pend_hi[src_pos(s)] = pend_q[s];
      end else begin
        mask_lo[src_pos(s)] = mask_q[s];
        pend_lo[src_pos(s)] = pend_q[s];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (word)
        WORD_W'(IDX_MASK_HI): rdata_o = mask_hi;
        WORD_W'(IDX_MASK_LO): rdata_o = mask_lo;
        WORD_W'(IDX_PEND_HI): rdata_o = pend_hi;
        WORD_W'(IDX_PEND_LO): rdata_o = pend_lo;
        WORD_W'(IDX_VEC):     rdata_o = {sel_idx, {(DATA_W-VEC_W){1'b0}}};
        WORD_W'(IDX_EDGE):    rdata_o = DATA_W'(edge_q);
        default:              rdata_o = '0;
      endcase
    end
  end

  // R5: a flag rises only after a detection
  a_r5_set_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(det_v)) == '0));
  // R7: a flag falls only after a one is written to it
  a_r7_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pend_q & $past(pend_q) & ~$past(clr_v)) == '0));
  // R9: a detection always leaves its flag set
  a_r9_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(det_v) & ~pend_q) == '0));
  // R8: the reported source is live whenever the request is up
  a_r8_vec_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_q[sel_idx] && mask_q[sel_idx]));
  a_r8_vec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (sel_idx == '0));
endmodule

// File: tb/irq_map_ctrl_bench.sv
`timescale 1ns/1ps
module irq_map_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [63:0] pend_m = '0, mask_m = '0;
  logic [31:0] edge_m = '0;

  always #2.5 clk = ~clk;

  irq_map_ctrl u_irq_map_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_ni  (src_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  localparam logic [4:0] A_MHI = 5'h00, A_MLO = 5'h04, A_PHI = 5'h08,
                         A_PLO = 5'h0C, A_VEC = 5'h10, A_EDG = 5'h14;

  function automatic bit b_hi(int s);
    return (s < 16) || (s >= 32 && s < 48);
  endfunction

  function automatic int b_pos(int s);
    int b;
    if (s == 0) b = 31;
    else if (s < 16) b = s + 15;
    else if (s == 16) b = 29;
    else if (s == 17) b = 30;
    else if (s == 31) b = 31;
    else if (s < 32) b = s - 2;
    else if (s < 48) b = s - 32;
    else b = 63 - s;
    return 31 - b;
  endfunction

  function automatic logic [31:0] exp_word(logic [63:0] v, bit hi);
    logic [31:0] w = '0;
    for (int s = 0; s < 64; s++) if (b_hi(s) == hi) w[b_pos(s)] = v[s];
    return w;
  endfunction

  function automatic logic [31:0] exp_vec();
    for (int s = 0; s < 64; s++) if (pend_m[s] && mask_m[s]) return {6'(s), 26'b0};
    return '0;
  endfunction

  function automatic bit is_edge(int s);
    return (s < 32) && edge_m[s];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // level sources that are low keep re-setting their flag
  task automatic refresh();
    for (int s = 0; s < 64; s++) if (!is_edge(s) && !src_n[s]) pend_m[s] = 1'b1;
  endtask

  task automatic set_src(logic [63:0] nv);
    @(negedge clk);
    for (int s = 0; s < 64; s++)
      if (is_edge(s) && src_n[s] && !nv[s]) pend_m[s] = 1'b1;
    src_n = nv;
    refresh();
    settle();
  endtask

  task automatic wr_mask(bit hi, logic [31:0] d);
    wr(hi ? A_MHI : A_MLO, d);
    for (int s = 0; s < 64; s++) if (b_hi(s) == hi) mask_m[s] = d[b_pos(s)];
    settle();
  endtask

  task automatic clr_pend(bit hi, logic [31:0] d);
    wr(hi ? A_PHI : A_PLO, d);
    for (int s = 0; s < 64; s++) if (b_hi(s) == hi && d[b_pos(s)]) pend_m[s] = 1'b0;
    refresh();
    settle();
  endtask

  task automatic wr_edge(logic [31:0] d);
    wr(A_EDG, d);
    edge_m = d;
    refresh();
    settle();
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    rd(A_MHI, d); check({tag, " R2 mask hi"}, d, exp_word(mask_m, 1'b1));
    rd(A_MLO, d); check({tag, " R2 mask lo"}, d, exp_word(mask_m, 1'b0));
    rd(A_PHI, d); check({tag, " R3 pend hi"}, d, exp_word(pend_m, 1'b1));
    rd(A_PLO, d); check({tag, " R3 pend lo"}, d, exp_word(pend_m, 1'b0));
    rd(A_VEC, d); check({tag, " R8 vector"}, d, exp_vec());
    rd(A_EDG, d); check({tag, " R6 trigger"}, d, edge_m);
    check({tag, " R2 irq"}, 32'(irq), 32'(|(pend_m & mask_m)));
  endtask

  task automatic map_probe(int s, logic [31:0] exp);
    logic [31:0] d;
    logic [63:0] v = '1;
    v[s] = 1'b0;
    set_src(v);
    rd(b_hi(s) ? A_PHI : A_PLO, d);
    check($sformatf("R3 R4 source %0d position", s), d, exp);
    set_src('1);
    clr_pend(b_hi(s), 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check_all("R1 reset");
    check("R1 irq low", 32'(irq), 32'd0);

    // R11 latency on level source 5 (bit 20 -> position 11)
    @(negedge clk) addr = A_PHI; src_n[5] = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R11 not yet after two edges", rdata, 32'h0);
    @(posedge clk); #1;
    check("R11 R5 set on third edge", rdata, 32'h0000_0800);
    pend_m[5] = 1'b1;
    settle();
    check("R2 masked no irq", 32'(irq), 32'd0);
    wr_mask(1'b1, 32'h0000_0800);
    check("R2 irq on enable", 32'(irq), 32'd1);
    rd(A_VEC, d); check("R8 vector source 5", d, 32'h1400_0000);

    // R7 write zero ignored; R5 level re-sets while low
    clr_pend(1'b1, 32'h0);
    rd(A_PHI, d); check("R7 zero write keeps flag", d, 32'h0000_0800);
    clr_pend(1'b1, 32'h0000_0800);
    rd(A_PHI, d); check("R5 level re-sets while low", d, 32'h0000_0800);
    set_src('1);
    clr_pend(1'b1, 32'h0000_0800);
    rd(A_PHI, d); check("R7 one write clears", d, 32'h0);
    check("R2 irq drops", 32'(irq), 32'd0);
    wr_mask(1'b1, 32'h0);

    // R3 R4 map spot checks
    map_probe(0,  32'h0000_0001);
    map_probe(1,  32'h0000_8000);
    map_probe(16, 32'h0000_0004);
    map_probe(17, 32'h0000_0002);
    map_probe(18, 32'h0000_8000);
    map_probe(31, 32'h0000_0001);
    map_probe(32, 32'h8000_0000);
    map_probe(47, 32'h0001_0000);
    map_probe(48, 32'h0001_0000);
    map_probe(63, 32'h8000_0000);

    // R6 edge mode on source 3 (bit 18 -> position 13)
    wr_edge(32'h0000_0008);
    set_src(~64'h8);
    rd(A_PHI, d); check("R6 edge sets", d, 32'h0000_2000);
    clr_pend(1'b1, 32'h0000_2000);
    rd(A_PHI, d); check("R6 no re-set while low", d, 32'h0);
    set_src('1);
    rd(A_PHI, d); check("R6 rising edge ignored", d, 32'h0);
    set_src(~64'h8);
    set_src('1);
    rd(A_PHI, d); check("R6 flag held after release", d, 32'h0000_2000);

    // R9 detection and clear on the same edge
    @(negedge clk) src_n[3] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) addr = A_PHI; wdata = 32'h0000_2000; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk) wr_en = 1'b0;
    #1 check("R9 set beats clear", rdata, 32'h0000_2000);
    settle();
    clr_pend(1'b1, 32'h0000_2000);
    rd(A_PHI, d); check("R9 later clear empties", d, 32'h0);
    set_src('1);

    // R8 lowest enabled source wins
    wr_mask(1'b1, 32'hFFFF_FFFF);
    wr_mask(1'b0, 32'hFFFF_FFFF);
    set_src(~((64'd1 << 40) | (64'd1 << 10)));
    rd(A_VEC, d); check("R8 lowest of 10 and 40", d, {6'd10, 26'b0});
    wr_mask(1'b1, exp_word(mask_m & ~(64'd1 << 10), 1'b1));
    rd(A_VEC, d); check("R8 masked 10 gives 40", d, {6'd40, 26'b0});

    // R10 read-only vector, unaligned and unmapped addresses
    wr(A_VEC, 32'hFFFF_FFFF);
    rd(A_VEC, d); check("R10 vector not writable", d, {6'd40, 26'b0});
    wr(5'h01, 32'h0);
    rd(A_MHI, d); check("R10 unaligned write ignored", d, exp_word(mask_m, 1'b1));
    rd(5'h01, d); check("R10 unaligned read zero", d, 32'h0);
    rd(5'h18, d); check("R10 unmapped read zero", d, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    check_all("R10 after unmapped write");
    set_src('1);
    clr_pend(1'b1, 32'hFFFF_FFFF);
    clr_pend(1'b0, 32'hFFFF_FFFF);
    check_all("R7 all ones clears");

    // random traffic
    for (int it = 0; it < 250; it++) begin
      int op = $urandom_range(0, 4);
      logic [31:0] r = $urandom();
      case (op)
        0: set_src({$urandom(), $urandom()} | {$urandom(), $urandom()});
        1: wr_mask(r[0], $urandom());
        2: clr_pend(r[1], $urandom());
        3: wr_edge($urandom());
        default: clr_pend(r[2], 32'hFFFF_FFFF);
      endcase
      check_all("rand R5 R6 R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule